// File: doc/BRIEF.md
# Supply-Fail Write-Protect Sequencer

This block is a clocked controller that sits between a small battery-backed 2K x 8 memory array and the supply monitor. It takes two digitized comparator levels: one says the supply is above the write-protect trip point, and the other says the supply is above the lower switchover level of about 3 V. From these two levels it decides three things. It decides when the memory bus may reach the array. It decides when the data pins must be forced to high impedance with every bus input ignored. It decides when the backup cell feeds the array instead of the external supply.

The backup cell leaves production sealed. The seal opens the first time the supply rises above the trip point. Until then a supply loss never switches the array onto the cell. Once open, the seal stays open through every later power cycle and closes again only when the factory-clear input is pulled low.

On power-up, access stays blocked for a recovery hold-off after the supply becomes valid. The default is 125 ms, which also covers the shorter minimum for holding the control strobes inactive. On power loss, access is cut off a few cycles after the debounced trip flag drops. The same trip level serves both threshold options (4.75 V / 4.5 V or 4.5 V / 4.25 V), because the comparator carries the analog choice.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low, `bus_en_o` is 0, `out_hiz_o` is 1 and `bkup_sel_o` is 0. Pulling `factory_n` low clears `seal_open_o` to 0 without waiting for a clock.
- R2: While `seal_open_o` is 0, `bkup_sel_o` is 0 for any level of `sw_ok_i`.
- R3: `seal_open_o` becomes 1 once the trip flag is seen high after filtering. It then stays 1 across later supply losses and deep drops until `factory_n` goes low.
- R4: REC_CYC is (CLK_HZ/1e6)*REC_US. Suppose `trip_ok_i` rises and stays high, and the first rising edge that samples it high is edge 0. Then `bus_en_o` is 0 through edge DEB_CYC+REC_CYC+1 and is 1 after edge DEB_CYC+REC_CYC+2.
- R5: Suppose `trip_ok_i` falls and stays low, and the first edge that samples it low is edge 0. Then `bus_en_o` is 0 and `out_hiz_o` is 1 after edge DEB_CYC+2.
- R6: A low pulse on `trip_ok_i` that is sampled by fewer than DEB_CYC consecutive edges does not disturb an enabled bus.
- R7: With the seal open and `trip_ok_i` low, `sw_ok_i` low connects the backup cell (`bkup_sel_o` = 1). `sw_ok_i` high again disconnects it within three edges.
- R8: `out_hiz_o` is the complement of `bus_en_o`, and `bus_en_o` and `bkup_sel_o` are never 1 together.
- R9: A trip-flag loss during the recovery hold-off abandons it. The next power-up waits the full R4 interval again.
- R10: `factory_n` going low while the backup cell is selected drops `bkup_sel_o` at once. The machine then returns to the sealed state, so the next deep drop does not select the cell.
- R11: If the filtered trip flag falls on the same edge at which the hold-off would complete, the bus stays disabled. If it falls one edge later, the bus is enabled for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset of the controller state |
| factory_n | input | 1 | Active-low factory clear of the seal, asynchronous |
| trip_ok_i | input | 1 | Supply above write-protect trip point (asynchronous) |
| sw_ok_i | input | 1 | Supply above backup switchover level (asynchronous) |
| bus_en_o | output | 1 | Memory bus may reach the array |
| out_hiz_o | output | 1 | Force data pins to high impedance and ignore bus inputs |
| bkup_sel_o | output | 1 | Backup cell powers the array |
| seal_open_o | output | 1 | Backup cell released for use |

## Verification
The delicate coincidence is between the hold-off counter reaching its end and the filtered trip flag falling, since both decide on the same edge whether the bus opens. The bench raises the trip input and drops it again exactly REC_CYC edges later, so that the filtered fall lands on the completion edge. It expects the bus never to open. It then repeats with the drop one edge later and expects exactly one enabled cycle. Random power-up, shallow-loss, deep-loss and glitch sequences surround these cases, and each is compared against a small bench model of seal and mode.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int REC_US  = 125_000,
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic factory_n,
  input  logic trip_ok_i,
  input  logic sw_ok_i,
  output logic bus_en_o,
  output logic out_hiz_o,
  output logic bkup_sel_o,
  output logic seal_open_o
);
  localparam int REC_CYC = (CLK_HZ / 1_000_000) * REC_US;
  localparam int RW = $clog2(REC_CYC + 1);
  localparam int DW = $clog2(DEB_CYC + 1);

  typedef enum logic [2:0] {
    M_SEALED, M_LIVE, M_GUARD, M_CELL, M_HOLD
  } mode_t;

  mode_t          mode, mode_nx;
  logic [1:0]     trip_sy, sw_sy;
  logic           trip_f, seal;
  logic [DW-1:0]  dcnt;
  logic [RW-1:0]  rcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trip_sy <= 2'b00;
      sw_sy   <= 2'b11;
    end else begin
      trip_sy <= {trip_sy[0], trip_ok_i};
      sw_sy   <= {sw_sy[0], sw_ok_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trip_f <= 1'b0;
      dcnt   <= '0;
    end else if (trip_sy[1] == trip_f) begin
      dcnt <= '0;
    end else if (dcnt == DW'(DEB_CYC - 1)) begin
      trip_f <= trip_sy[1];
      dcnt   <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         rcnt <= '0;
    else if (!trip_f || mode != M_HOLD) rcnt <= '0;
    else                                rcnt <= rcnt + 1'b1;

  always_ff @(posedge clk or negedge factory_n)
    if (!factory_n)  seal <= 1'b0;
    else if (trip_f) seal <= 1'b1;

  always_comb begin
    mode_nx = mode;
    case (mode)
      M_SEALED: if (trip_f)                       mode_nx = M_HOLD;
                else if (seal)                    mode_nx = M_GUARD;
      M_HOLD:   if (!trip_f)                      mode_nx = seal ? M_GUARD : M_SEALED;
                else if (rcnt == RW'(REC_CYC - 1)) mode_nx = M_LIVE;
      M_LIVE:   if (!trip_f)                      mode_nx = M_GUARD;
      M_GUARD:  if (!seal)                        mode_nx = M_SEALED;
                else if (trip_f)                  mode_nx = M_HOLD;
                else if (!sw_sy[1])               mode_nx = M_CELL;
      M_CELL:   if (!seal)                        mode_nx = M_SEALED;
                else if (sw_sy[1])                mode_nx = M_GUARD;
      default:                                    mode_nx = M_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= M_SEALED;
    else        mode <= mode_nx;

  assign bus_en_o    = (mode == M_LIVE);
  assign out_hiz_o   = !bus_en_o;
  assign bkup_sel_o  = (mode == M_CELL) && seal;
  assign seal_open_o = seal;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int REC_CYC = 8,
  parameter int DEB_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic factory_n,
  input logic trip_ok_i,
  input logic sw_ok_i,
  input logic bus_en_o,
  input logic out_hiz_o,
  input logic bkup_sel_o,
  input logic seal_open_o
);
  int off_run, low_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      off_run <= 0;
      low_run <= 0;
    end else begin
      if (bus_en_o)                        off_run <= 0;
      else if (off_run < 1_000_000_000)    off_run <= off_run + 1;
      if (trip_ok_i)                       low_run <= 0;
      else if (low_run < 1_000_000_000)    low_run <= low_run + 1;
    end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en_o && (out_hiz_o || bkup_sel_o)));

  p_sealed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seal_open_o |-> !bkup_sel_o);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n || !factory_n)
    seal_open_o |=> seal_open_o);

  p_holdoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en_o) |-> off_run >= REC_CYC);

  p_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run >= DEB_CYC + 3) |-> !bus_en_o);

  p_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bkup_sel_o) |-> $past(!sw_ok_i, 3));
endmodule

bind supply_guard supply_guard_chk #(.REC_CYC(REC_CYC), .DEB_CYC(DEB_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .trip_ok_i(trip_ok_i),
  .sw_ok_i(sw_ok_i), .bus_en_o(bus_en_o), .out_hiz_o(out_hiz_o),
  .bkup_sel_o(bkup_sel_o), .seal_open_o(seal_open_o)
);

// File: tb/supply_guard_tb_top.sv
module supply_guard_tb_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int REC_US = 40;
  localparam int DEB    = 3;
  localparam int REC    = (CLK_HZ / 1_000_000) * REC_US;

  logic clk = 1'b0;
  logic rst_n, factory_n, trip, sw;
  logic bus_en, out_hiz, bkup_sel, seal_open;
  int   n_cmp = 0, n_bad = 0;
  bit   m_act = 0, m_seal = 0, m_deep = 0, done = 0;

  always #10 clk = ~clk;

  supply_guard #(.CLK_HZ(CLK_HZ), .REC_US(REC_US), .DEB_CYC(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .trip_ok_i(trip),
    .sw_ok_i(sw), .bus_en_o(bus_en), .out_hiz_o(out_hiz),
    .bkup_sel_o(bkup_sel), .seal_open_o(seal_open)
  );

  function automatic logic exp_cell();
    return !m_act && m_deep && m_seal;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " bus_en R8"}, bus_en, m_act);
    chk({tag, " out_hiz R8"}, out_hiz, !m_act);
    chk({tag, " bkup_sel R7"}, bkup_sel, exp_cell());
    chk({tag, " seal R3"}, seal_open, m_seal);
  endtask

  task automatic power_up();
    @(negedge clk); sw = 1'b1; trip = 1'b1;
    repeat (2 + DEB + REC) @(posedge clk);
    @(negedge clk); chk("R4 still held off", bus_en, 1'b0);
    @(posedge clk);
    @(negedge clk);
    m_act = 1; m_seal = 1; m_deep = 0;
    chk_all("R4 enabled");
  endtask

  task automatic power_down(input bit deep);
    @(negedge clk); trip = 1'b0; sw = !deep;
    repeat (DEB + 3) @(posedge clk);
    @(negedge clk); chk("R5 cut off", bus_en, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_act = 0; m_deep = deep;
    chk_all(deep ? "R7 deep drop" : "R5 shallow drop");
  endtask

  task automatic glitch();
    @(negedge clk); trip = 1'b0;
    repeat (DEB - 1) @(negedge clk);
    trip = 1'b1;
    for (int i = 0; i < DEB + 6; i++) begin
      @(negedge clk); chk("R6 short glitch", bus_en, 1'b1);
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int hi_cnt;
    rst_n = 1'b0; factory_n = 1'b0; trip = 1'b0; sw = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); factory_n = 1'b1;
    chk("R1 reset bus_en", bus_en, 1'b0);
    chk("R1 reset out_hiz", out_hiz, 1'b1);
    chk("R1 reset bkup_sel", bkup_sel, 1'b0);
    chk("R1 reset seal", seal_open, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    power_down(1);
    chk("R2 sealed deep drop", bkup_sel, 1'b0);
    power_up();
    glitch();
    power_down(1);
    power_down(0);

    @(negedge clk); trip = 1'b1;
    repeat (REC / 2) @(posedge clk);
    @(negedge clk); trip = 1'b0;
    repeat (DEB + 6) @(posedge clk);
    @(negedge clk); chk("R9 aborted hold-off", bus_en, 1'b0);
    power_up();

    power_down(0);
    @(negedge clk); trip = 1'b1;
    repeat (REC) @(posedge clk);
    @(negedge clk); trip = 1'b0;
    hi_cnt = 0;
    for (int i = 0; i < REC + DEB + 10; i++) begin
      @(negedge clk); if (bus_en) hi_cnt++;
    end
    chk("R11 same-edge loss keeps bus off", hi_cnt == 0, 1'b1);
    trip = 1'b1;
    repeat (REC + 1) @(posedge clk);
    @(negedge clk); trip = 1'b0;
    hi_cnt = 0;
    for (int i = 0; i < REC + DEB + 10; i++) begin
      @(negedge clk); if (bus_en) hi_cnt++;
    end
    chk("R11 one-edge-late loss gives one cycle", hi_cnt == 1, 1'b1);
    m_act = 0; m_deep = 0;

    power_down(1);
    @(negedge clk); factory_n = 1'b0;
    #1;
    chk("R10 clear drops cell", bkup_sel, 1'b0);
    chk("R1 clear drops seal", seal_open, 1'b0);
    @(negedge clk); factory_n = 1'b1;
    m_seal = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); chk_all("R10 resealed");
    power_up();

    void'($urandom(32'd2024));
    for (int k = 0; k < 30; k++) begin
      case ($urandom % 4)
        0: if (!m_act) power_up(); else glitch();
        1: if (m_act) power_down(0); else power_up();
        2: power_down(1);
        default: if (m_act) glitch(); else power_down($urandom % 2);
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule